// File: doc/BRIEF.md
# Level-0 Filter Cache with Runtime Bypass

This block is a very small direct-mapped cache that sits between a processor load/store port and a slower first-level cache port. Every processor access is looked up here first. A read that finds its line is answered in the cycle after it is accepted and never touches the L1 side. A read that misses fetches the whole 16-byte line from L1, one 32-bit word at a time, installs it, and then answers. Stores are written through to L1 on every access. A store that hits also updates the cached word. A store that misses does not allocate a line.

A bypass input takes the cache out of the path. While it is high, each accepted access is passed to L1 as one single-word access. The arrays and the event counters are left alone. When bypass drops, every line is invalidated, so data that L1 changed meanwhile is never served from a stale line. Two counters report the hits and misses seen on non-bypassed accesses. Only one access is in flight at any time.

Top module: `filter_cache_l0`

## Requirements
- R1: After reset, `cpu_req_ready` is high, `cpu_rsp_valid` and `l1_req_valid` are low, both counters read zero, and every line is invalid, so the first read of any address misses.
- R2: A non-bypassed read that hits gives `cpu_rsp_valid` with the cached word in the cycle after acceptance. It issues no L1 request and adds one to `hit_count`.
- R3: A non-bypassed read miss adds one to `miss_count` and issues four L1 reads, one at a time, at line base + 0, 4, 8 and 12 in that order. Its response carries the word selected by address bits [3:2] and follows the last beat.
- R4: Once a refill completes, reads of any word of that line hit until the line is evicted or invalidated.
- R5: The mapping is direct. The line index is address bits [OFF_W+IDX_W-1:OFF_W] (bits [7:4] at 256 bytes, bits [6:4] at 128 bytes), and the tag is every bit above them. A read miss to a different tag at the same index replaces the line.
- R6: Every accepted store is forwarded to L1 as one write with the same address and data. Its response pulse (read data zero) comes in the cycle after L1 accepts. A store hit also updates the cached word, so a later read hit returns the new data.
- R7: A store miss allocates nothing. The line stays invalid, so a later read of it misses. It counts one miss.
- R8: With `bypass_en` high, each accepted access becomes one L1 access with the unchanged address. A read returns the L1 data. Neither counter changes and no line is installed.
- R9: In the cycle after `bypass_en` falls, `cpu_req_ready` is low and all lines are invalidated.
- R10: At most one access is outstanding. `cpu_req_ready` is low whenever `l1_req_valid` is high. An L1 request holds its address, data and direction until accepted.
- R11: `hit_count` + `miss_count` rises by at most one per cycle. It equals the number of accepted non-bypassed accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Route all accesses straight to L1 |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted on this edge when valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address, word aligned |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 32 | Load data (zero for stores) |
| l1_req_valid | output | 1 | Request to L1 present |
| l1_req_ready | input | 1 | L1 accepts the request |
| l1_req_write | output | 1 | 1 = write, 0 = single-word read |
| l1_req_addr | output | 32 | L1 word address |
| l1_req_wdata | output | 32 | L1 write data |
| l1_rsp_valid | input | 1 | One L1 read word returned |
| l1_rsp_rdata | input | 32 | L1 read data |
| hit_count | output | 32 | Non-bypassed hits since reset |
| miss_count | output | 32 | Non-bypassed misses since reset |

## Verification
Several properties are checked on every cycle. A read hit answers the next cycle with no L1 traffic. A read miss starts at the line base. Stores always reach L1. Bypassed accesses leave the counters alone. Ready stays low while L1 is engaged, and again in the cycle bypass is released. L1 requests hold steady until accepted. Other behaviour is visible only through the directed scenarios and the reference model. These cover refill word order, returned data, eviction on a conflicting tag, the absence of allocation on store misses, and stale lines being discarded after a bypass period in which L1 was written.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int WORD_LSB       = $clog2(BYTES_PER_WORD);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BYP_REQ,
        S_BYP_WAIT,
        S_FILL_REQ,
        S_FILL_WAIT,
        S_WT_REQ
    } fc_state_e;

    typedef struct packed {
        logic  write;
        addr_t addr;
        word_t wdata;
    } fc_req_t;

    function automatic int fc_line_count(int cap_bytes, int line_bytes);
        return cap_bytes / line_bytes;
    endfunction

endpackage

// File: rtl/fc_tag_store.sv
module fc_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [NUM_LINES-1:0] valid_vec;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic v_q;
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                v_q <= 1'b1;
            end
        end
        assign valid_vec[i] = v_q;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/fc_data_store.sv
module fc_data_store
    import fc_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int WPL       = 4,
    parameter int IDX_W     = 4,
    parameter int WSEL_W    = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  word_t             wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output word_t             rd_data
);

    localparam int DEPTH = NUM_LINES * WPL;

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_wsel}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_wsel}];

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int WPL     = 4,
    parameter int IDX_W   = 4,
    parameter int WSEL_W  = 2,
    parameter int TAG_W   = 24,
    parameter int OFF_W   = 4,
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bypass_en,
    input  logic               cpu_req_valid,
    output logic               cpu_req_ready,
    input  logic               cpu_req_write,
    input  addr_t              cpu_req_addr,
    input  word_t              cpu_req_wdata,
    output logic               cpu_rsp_valid,
    output word_t              cpu_rsp_rdata,
    output logic               l1_req_valid,
    input  logic               l1_req_ready,
    output logic               l1_req_write,
    output addr_t              l1_req_addr,
    output word_t              l1_req_wdata,
    input  logic               l1_rsp_valid,
    input  word_t              l1_rsp_rdata,
    input  logic [IDX_W-1:0]   lk_idx,
    input  logic [WSEL_W-1:0]  lk_wsel,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic               lk_valid,
    input  logic [TAG_W-1:0]   lk_tag,
    input  word_t              lk_word,
    output logic               tag_flush,
    output logic               tag_wr_en,
    output logic [IDX_W-1:0]   tag_wr_idx,
    output logic [TAG_W-1:0]   tag_wr_tag,
    output logic               dat_wr_en,
    output logic [IDX_W-1:0]   dat_wr_idx,
    output logic [WSEL_W-1:0]  dat_wr_wsel,
    output word_t              dat_wr_data,
    output logic [COUNT_W-1:0] hit_count,
    output logic [COUNT_W-1:0] miss_count
);

    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPL - 1);

    fc_state_e          state_q;
    fc_req_t            req_q;
    logic [WSEL_W-1:0]  beat_q;
    word_t              pick_q;
    logic               rsp_valid_q;
    word_t              rsp_data_q;
    logic [COUNT_W-1:0] hit_q;
    logic [COUNT_W-1:0] miss_q;
    logic               byp_q;

    logic               accept;
    logic               lookup_hit;
    logic               fill_beat;
    logic               store_hit;
    logic [IDX_W-1:0]   req_idx;
    logic [WSEL_W-1:0]  req_wsel;

    assign req_idx    = req_q.addr[OFF_W +: IDX_W];
    assign req_wsel   = req_q.addr[WORD_LSB +: WSEL_W];
    assign tag_flush  = byp_q && !bypass_en;
    assign cpu_req_ready = (state_q == S_IDLE) && !tag_flush;
    assign accept     = cpu_req_valid && cpu_req_ready;
    assign lookup_hit = lk_valid && (lk_tag == req_tag);
    assign fill_beat  = (state_q == S_FILL_WAIT) && l1_rsp_valid;
    assign store_hit  = accept && cpu_req_write && !bypass_en && lookup_hit;

    // Array write ports: refill beats and store hits never coincide
    always_comb begin
        dat_wr_en   = fill_beat || store_hit;
        dat_wr_idx  = fill_beat ? req_idx : lk_idx;
        dat_wr_wsel = fill_beat ? beat_q : lk_wsel;
        dat_wr_data = fill_beat ? l1_rsp_rdata : cpu_req_wdata;
        tag_wr_en   = fill_beat && (beat_q == LAST_BEAT);
        tag_wr_idx  = req_idx;
        tag_wr_tag  = req_q.addr[ADDR_W-1 -: TAG_W];
    end

    // L1 request port
    always_comb begin
        l1_req_valid = (state_q == S_BYP_REQ) || (state_q == S_FILL_REQ) ||
                       (state_q == S_WT_REQ);
        l1_req_write = req_q.write && (state_q != S_FILL_REQ);
        l1_req_addr  = (state_q == S_FILL_REQ) ?
                       {req_q.addr[ADDR_W-1:OFF_W], beat_q, {WORD_LSB{1'b0}}} :
                       req_q.addr;
        l1_req_wdata = req_q.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            req_q       <= '0;
            beat_q      <= '0;
            pick_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            hit_q       <= '0;
            miss_q      <= '0;
            byp_q       <= 1'b0;
        end else begin
            byp_q       <= bypass_en;
            rsp_valid_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        req_q.write <= cpu_req_write;
                        req_q.addr  <= cpu_req_addr;
                        req_q.wdata <= cpu_req_wdata;
                        if (bypass_en) begin
                            state_q <= S_BYP_REQ;
                        end else begin
                            if (lookup_hit) begin
                                hit_q <= hit_q + COUNT_W'(1);
                            end else begin
                                miss_q <= miss_q + COUNT_W'(1);
                            end
                            if (cpu_req_write) begin
                                state_q <= S_WT_REQ;
                            end else if (lookup_hit) begin
                                rsp_valid_q <= 1'b1;
                                rsp_data_q  <= lk_word;
                            end else begin
                                beat_q  <= '0;
                                state_q <= S_FILL_REQ;
                            end
                        end
                    end
                end
                S_BYP_REQ: begin
                    if (l1_req_ready) begin
                        if (req_q.write) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= '0;
                            state_q     <= S_IDLE;
                        end else begin
                            state_q <= S_BYP_WAIT;
                        end
                    end
                end
                S_BYP_WAIT: begin
                    if (l1_rsp_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= l1_rsp_rdata;
                        state_q     <= S_IDLE;
                    end
                end
                S_FILL_REQ: begin
                    if (l1_req_ready) begin
                        state_q <= S_FILL_WAIT;
                    end
                end
                S_FILL_WAIT: begin
                    if (l1_rsp_valid) begin
                        if (beat_q == req_wsel) begin
                            pick_q <= l1_rsp_rdata;
                        end
                        if (beat_q == LAST_BEAT) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= (beat_q == req_wsel) ? l1_rsp_rdata : pick_q;
                            beat_q      <= '0;
                            state_q     <= S_IDLE;
                        end else begin
                            beat_q  <= beat_q + WSEL_W'(1);
                            state_q <= S_FILL_REQ;
                        end
                    end
                end
                S_WT_REQ: begin
                    if (l1_req_ready) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= '0;
                        state_q     <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_rdata = rsp_data_q;
    assign hit_count     = hit_q;
    assign miss_count    = miss_q;

endmodule

// File: rtl/filter_cache_l0.sv
module filter_cache_l0
    import fc_pkg::*;
#(
    parameter int CAP_BYTES  = 256,
    parameter int LINE_BYTES = 16,
    parameter int COUNT_W    = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bypass_en,
    input  logic               cpu_req_valid,
    output logic               cpu_req_ready,
    input  logic               cpu_req_write,
    input  logic [31:0]        cpu_req_addr,
    input  logic [31:0]        cpu_req_wdata,
    output logic               cpu_rsp_valid,
    output logic [31:0]        cpu_rsp_rdata,
    output logic               l1_req_valid,
    input  logic               l1_req_ready,
    output logic               l1_req_write,
    output logic [31:0]        l1_req_addr,
    output logic [31:0]        l1_req_wdata,
    input  logic               l1_rsp_valid,
    input  logic [31:0]        l1_rsp_rdata,
    output logic [COUNT_W-1:0] hit_count,
    output logic [COUNT_W-1:0] miss_count
);

    localparam int NUM_LINES = fc_line_count(CAP_BYTES, LINE_BYTES);
    localparam int WPL       = LINE_BYTES / BYTES_PER_WORD;
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int WSEL_W    = $clog2(WPL);
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [WSEL_W-1:0] lk_wsel;
    logic [TAG_W-1:0]  req_tag;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    word_t             lk_word;
    logic              tag_flush;
    logic              tag_wr_en;
    logic [IDX_W-1:0]  tag_wr_idx;
    logic [TAG_W-1:0]  tag_wr_tag;
    logic              dat_wr_en;
    logic [IDX_W-1:0]  dat_wr_idx;
    logic [WSEL_W-1:0] dat_wr_wsel;
    word_t             dat_wr_data;

    assign lk_idx  = cpu_req_addr[OFF_W +: IDX_W];
    assign lk_wsel = cpu_req_addr[WORD_LSB +: WSEL_W];
    assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];

    fc_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .flush    (tag_flush),
        .rd_idx   (lk_idx),
        .rd_valid (lk_valid),
        .rd_tag   (lk_tag),
        .wr_en    (tag_wr_en),
        .wr_idx   (tag_wr_idx),
        .wr_tag   (tag_wr_tag)
    );

    fc_data_store #(
        .NUM_LINES (NUM_LINES),
        .WPL       (WPL),
        .IDX_W     (IDX_W),
        .WSEL_W    (WSEL_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (dat_wr_en),
        .wr_idx  (dat_wr_idx),
        .wr_wsel (dat_wr_wsel),
        .wr_data (dat_wr_data),
        .rd_idx  (lk_idx),
        .rd_wsel (lk_wsel),
        .rd_data (lk_word)
    );

    fc_ctrl #(
        .WPL     (WPL),
        .IDX_W   (IDX_W),
        .WSEL_W  (WSEL_W),
        .TAG_W   (TAG_W),
        .OFF_W   (OFF_W),
        .COUNT_W (COUNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bypass_en     (bypass_en),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_ready (cpu_req_ready),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_rdata (cpu_rsp_rdata),
        .l1_req_valid  (l1_req_valid),
        .l1_req_ready  (l1_req_ready),
        .l1_req_write  (l1_req_write),
        .l1_req_addr   (l1_req_addr),
        .l1_req_wdata  (l1_req_wdata),
        .l1_rsp_valid  (l1_rsp_valid),
        .l1_rsp_rdata  (l1_rsp_rdata),
        .lk_idx        (lk_idx),
        .lk_wsel       (lk_wsel),
        .req_tag       (req_tag),
        .lk_valid      (lk_valid),
        .lk_tag        (lk_tag),
        .lk_word       (lk_word),
        .tag_flush     (tag_flush),
        .tag_wr_en     (tag_wr_en),
        .tag_wr_idx    (tag_wr_idx),
        .tag_wr_tag    (tag_wr_tag),
        .dat_wr_en     (dat_wr_en),
        .dat_wr_idx    (dat_wr_idx),
        .dat_wr_wsel   (dat_wr_wsel),
        .dat_wr_data   (dat_wr_data),
        .hit_count     (hit_count),
        .miss_count    (miss_count)
    );

endmodule

// File: rtl/fc_checker.sv
module fc_checker
    import fc_pkg::*;
#(
    parameter int CAP_BYTES  = 256,
    parameter int LINE_BYTES = 16,
    parameter int COUNT_W    = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bypass_en,
    input logic               cpu_req_valid,
    input logic               cpu_req_ready,
    input logic               cpu_req_write,
    input logic [31:0]        cpu_req_wdata,
    input logic               cpu_rsp_valid,
    input logic               l1_req_valid,
    input logic               l1_req_ready,
    input logic               l1_req_write,
    input logic [31:0]        l1_req_addr,
    input logic [31:0]        l1_req_wdata,
    input logic [COUNT_W-1:0] hit_count,
    input logic [COUNT_W-1:0] miss_count,
    input logic               lk_valid,
    input logic [ADDR_W-$clog2(CAP_BYTES)-1:0] lk_tag,
    input logic [ADDR_W-$clog2(CAP_BYTES)-1:0] req_tag
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    logic accept;
    logic [COUNT_W-1:0] total;

    assign accept = cpu_req_valid && cpu_req_ready;
    assign total  = hit_count + miss_count;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (hit_count == '0 && miss_count == '0 &&
                        !cpu_rsp_valid && !l1_req_valid && cpu_req_ready));

    a_r2_hit_answers_next: assert property (@(posedge clk) disable iff (rst)
        (accept && !bypass_en && !cpu_req_write && lk_valid && lk_tag == req_tag)
        |=> (cpu_rsp_valid && !l1_req_valid &&
             hit_count == $past(hit_count) + COUNT_W'(1)));

    a_r3_miss_starts_at_base: assert property (@(posedge clk) disable iff (rst)
        (accept && !bypass_en && !cpu_req_write && !(lk_valid && lk_tag == req_tag))
        |=> (l1_req_valid && !l1_req_write && l1_req_addr[OFF_W-1:0] == '0));

    a_r6_store_forwarded: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_req_write)
        |=> (l1_req_valid && l1_req_write && l1_req_wdata == $past(cpu_req_wdata)));

    a_r8_bypass_no_count: assert property (@(posedge clk) disable iff (rst)
        (accept && bypass_en)
        |=> (hit_count == $past(hit_count) && miss_count == $past(miss_count)));

    a_r9_release_blocks: assert property (@(posedge clk) disable iff (rst)
        $fell(bypass_en) |-> !cpu_req_ready);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        l1_req_valid |-> !cpu_req_ready);

    a_r10_l1_req_stable: assert property (@(posedge clk) disable iff (rst)
        (l1_req_valid && !l1_req_ready)
        |=> (l1_req_valid && $stable(l1_req_addr) && $stable(l1_req_wdata) &&
             $stable(l1_req_write)));

    a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((total - $past(total)) <= COUNT_W'(1)));

endmodule

bind filter_cache_l0 fc_checker #(
    .CAP_BYTES  (CAP_BYTES),
    .LINE_BYTES (LINE_BYTES),
    .COUNT_W    (COUNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bypass_en     (bypass_en),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .l1_req_valid  (l1_req_valid),
    .l1_req_ready  (l1_req_ready),
    .l1_req_write  (l1_req_write),
    .l1_req_addr   (l1_req_addr),
    .l1_req_wdata  (l1_req_wdata),
    .hit_count     (hit_count),
    .miss_count    (miss_count),
    .lk_valid      (lk_valid),
    .lk_tag        (lk_tag),
    .req_tag       (req_tag)
);

// File: tb/filter_cache_l0_tb.sv
`timescale 1ns/1ps
module filter_cache_l0_tb;

    localparam int NLINES = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass_en = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        l1_req_valid;
    logic        l1_req_ready;
    logic        l1_req_write;
    logic [31:0] l1_req_addr;
    logic [31:0] l1_req_wdata;
    logic        l1_rsp_valid;
    logic [31:0] l1_rsp_rdata;
    logic [31:0] hit_count;
    logic [31:0] miss_count;

    int checks = 0;
    int fails  = 0;
    int exp_hit = 0;
    int exp_miss = 0;
    int l1_lat = 1;
    int l1_rd_n = 0;
    int l1_wr_n = 0;
    logic [31:0] rd_log [8];
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic [31:0] l1_store [logic [31:0]];
    logic        ref_valid [NLINES];
    logic [23:0] ref_tag [NLINES];

    always #2.5 clk = ~clk;

    filter_cache_l0 u_dut (
        .clk(clk), .rst(rst), .bypass_en(bypass_en),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata), .l1_req_valid(l1_req_valid),
        .l1_req_ready(l1_req_ready), .l1_req_write(l1_req_write),
        .l1_req_addr(l1_req_addr), .l1_req_wdata(l1_req_wdata),
        .l1_rsp_valid(l1_rsp_valid), .l1_rsp_rdata(l1_rsp_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] l1_val(logic [31:0] a);
        if (l1_store.exists(a)) return l1_store[a];
        return a ^ 32'h5EED_0000;
    endfunction

    function automatic logic ref_hit(logic [31:0] a);
        return ref_valid[a[7:4]] && (ref_tag[a[7:4]] == a[31:8]);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural L1: fixed latency before accept and before each read word
    initial begin
        logic [31:0] la, ld;
        logic lw;
        l1_req_ready = 1'b0;
        l1_rsp_valid = 1'b0;
        l1_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            l1_req_ready = 1'b0;
            l1_rsp_valid = 1'b0;
            if (l1_req_valid && !rst) begin
                repeat (l1_lat) @(negedge clk);
                la = l1_req_addr; lw = l1_req_write; ld = l1_req_wdata;
                l1_req_ready = 1'b1;
                @(negedge clk);
                l1_req_ready = 1'b0;
                if (lw) begin
                    l1_store[la] = ld;
                    last_wr_addr = la;
                    last_wr_data = ld;
                    l1_wr_n++;
                end else begin
                    rd_log[l1_rd_n % 8] = la;
                    l1_rd_n++;
                    repeat (l1_lat) @(negedge clk);
                    l1_rsp_valid = 1'b1;
                    l1_rsp_rdata = l1_val(la);
                end
            end
        end
    end

    task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat, output logic busy);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        busy = !cpu_req_ready;
        lat = 1;
        while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
        rd = cpu_rsp_rdata;
    endtask

    task automatic do_read(input string r, input logic [31:0] a);
        logic [31:0] rd; int lat; logic busy; logic eh; int n0;
        eh = ref_hit(a); n0 = l1_rd_n;
        access(1'b0, a, '0, rd, lat, busy);
        check(r, "read data", rd, l1_val(a));
        if (eh) begin
            check(r, "hit answers next cycle", lat, 1);
            check(r, "hit makes no L1 read", l1_rd_n - n0, 0);
            exp_hit++;
        end else begin
            check(r, "miss takes longer", 32'(lat > 1), 1);
            check(r, "miss reads four words", l1_rd_n - n0, 4);
            check("R10", "ready low during refill", 32'(busy), 1);
            exp_miss++;
            ref_valid[a[7:4]] = 1'b1;
            ref_tag[a[7:4]] = a[31:8];
        end
    endtask

    task automatic do_write(input string r, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] rd; int lat; logic busy; int n0;
        if (ref_hit(a)) exp_hit++; else exp_miss++;
        n0 = l1_wr_n;
        access(1'b1, a, d, rd, lat, busy);
        check(r, "store reaches L1 once", l1_wr_n - n0, 1);
        check(r, "store address", last_wr_addr, a);
        check(r, "store data", last_wr_data, d);
        check(r, "store response data", rd, '0);
    endtask

    task automatic check_counts(input string r);
        check(r, "hit_count", hit_count, exp_hit);
        check(r, "miss_count", miss_count, exp_miss);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1", "ready after reset", 32'(cpu_req_ready), 1);
        check("R1", "no response after reset", 32'(cpu_rsp_valid), 0);
        check("R1", "no L1 request after reset", 32'(l1_req_valid), 0);
        check_counts("R1");
    endtask

    task automatic test_refill_order();
        int n0;
        n0 = l1_rd_n;
        l1_lat = 1;
        do_read("R3", 32'h0000_1048);
        for (int k = 0; k < 4; k++)
            check("R3", "refill word order", rd_log[(n0 + k) % 8], 32'h0000_1040 + 32'(4 * k));
        check_counts("R3");
    endtask

    task automatic test_line_hits();
        do_read("R4", 32'h0000_1040);
        do_read("R4", 32'h0000_104C);
        do_read("R2", 32'h0000_1044);
        check_counts("R2");
    endtask

    task automatic test_conflict();
        do_read("R5", 32'h0000_2040);
        do_read("R5", 32'h0000_1040);
        do_read("R5", 32'h0000_1050);
        do_read("R5", 32'h0000_1054);
        check_counts("R5");
    endtask

    task automatic test_store_hit();
        do_write("R6", 32'h0000_1044, 32'hCAFE_0001);
        do_read("R6", 32'h0000_1044);
        l1_lat = 3;
        do_write("R6", 32'h0000_1040, 32'hCAFE_0002);
        do_read("R6", 32'h0000_1040);
        l1_lat = 1;
        check_counts("R6");
    endtask

    task automatic test_store_miss();
        do_write("R7", 32'h0000_3080, 32'hBEEF_0003);
        do_read("R7", 32'h0000_3080);
        check_counts("R7");
    endtask

    task automatic test_bypass();
        logic [31:0] rd; int lat; logic busy; int n0;
        @(negedge clk); bypass_en = 1'b1;
        n0 = l1_rd_n;
        access(1'b0, 32'h0000_1044, '0, rd, lat, busy);
        check("R8", "bypass read data", rd, l1_val(32'h0000_1044));
        check("R8", "bypass read goes to L1", l1_rd_n - n0, 1);
        check("R8", "bypass read address", rd_log[n0 % 8], 32'h0000_1044);
        n0 = l1_wr_n;
        access(1'b1, 32'h0000_1044, 32'hD00D_0004, rd, lat, busy);
        check("R8", "bypass write goes to L1", l1_wr_n - n0, 1);
        check("R8", "bypass write data", last_wr_data, 32'hD00D_0004);
        n0 = l1_rd_n;
        access(1'b0, 32'h0000_5000, '0, rd, lat, busy);
        check("R8", "bypass miss address", rd_log[n0 % 8], 32'h0000_5000);
        check_counts("R8");
        @(negedge clk); bypass_en = 1'b0;
        #0.1;
        check("R9", "ready low on release", 32'(cpu_req_ready), 0);
        @(negedge clk);
        check("R9", "ready back after release", 32'(cpu_req_ready), 1);
        for (int i = 0; i < NLINES; i++) ref_valid[i] = 1'b0;
        do_read("R9", 32'h0000_1044);
        do_read("R8", 32'h0000_5000);
        check_counts("R9");
    endtask

    task automatic test_random();
        logic [15:0] lfsr;
        logic [31:0] a;
        lfsr = 16'hACE1;
        for (int i = 0; i < 160; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = 32'h0000_8000 | {22'h0, lfsr[9:2], 2'b00};
            l1_lat = i % 3;
            if (lfsr[15:14] == 2'b11) do_write("R6", a, {lfsr, lfsr ^ 16'h1234});
            else do_read("R4", a);
        end
        l1_lat = 1;
        check_counts("R11");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < NLINES; i++) begin ref_valid[i] = 1'b0; ref_tag[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        test_reset();
        test_refill_order();
        test_line_hits();
        test_conflict();
        test_store_hit();
        test_store_miss();
        test_bypass();
        test_random();
        repeat (4) @(negedge clk);
        summary();
    end

endmodule